// File: doc/BRIEF.md
# XOR Sprite Blitter with Collision Detect

This block draws a monochrome sprite, one byte wide and up to fifteen rows tall, into a 64 by 32 pixel frame buffer kept in ordinary byte-addressed memory at one bit per pixel. Within each frame-buffer byte, the most significant bit is the leftmost pixel. A strobe latches the draw request: the X and Y position, the number of rows, the address of the sprite bytes and the base address of the frame buffer. After the strobe, the block walks the rows on its own. For each row it fetches the sprite byte and the frame-buffer bytes that the row covers. It XORs the sprite pixels into those bytes and stores them back. It reports whether any pixel that was lit got switched off.

The block drives a single-port synchronous memory through a request/ready handshake. The memory may hold off any access by keeping `mem_ready` low. The block then holds the request, address, write flag and write data steady until the memory accepts. Read data is taken from `mem_rdata` exactly one cycle after the memory accepts a read. A draw can also ask for a frame stall. In that case the `stall` output tells the surrounding processor to wait for the next frame tick once the draw has finished.

Top module: `xor_blitter`

## Requirements
- R1: The position is taken modulo the screen size when the request is latched: X modulo 64, Y modulo 32.
- R2: For row r, the sprite byte is read from the sprite address plus r. The frame-buffer byte is at base + ((Y+r) mod 32)*8 + X/8. Bit 7 of every byte is its leftmost pixel.
- R3: The sprite byte is shifted right by X mod 8 inside a 16-bit window. The upper half is XORed into the addressed byte and the lower half into the byte that follows it.
- R4: The following byte is read and written only when X mod 8 is not zero and X/8 is not 7. Pixels that would pass column 63 are dropped, and the block never writes outside the 256-byte frame buffer.
- R5: A row with Y+r ≥ 32 is not drawn, and the draw ends at the first such row. The sprite bytes for the rows that are not drawn are never read.
- R6: The collision output is cleared when a request is latched. It is then set if any sprite pixel of 1 lands on a frame-buffer pixel that is already 1, and it holds its value until the next request.
- R7: `busy` goes high in the cycle after an accepted start and stays high until the last write is accepted. `done` is high for exactly the one cycle that follows, with `busy` low, while `collision` holds the result. A start seen while `busy` is high is ignored.
- R8: A request with a row count of zero makes no memory access. `done` is then high in the first cycle after the start, and `collision` reads 0.
- R9: A request that is not accepted keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ready` is high. Back-pressure adds cycles but never changes the memory contents or the collision result.
- R10: Each row accesses memory in a fixed order: sprite read, first-byte read, second-byte read, first-byte write, second-byte write. The two second-byte steps appear only as allowed by R4. With `mem_ready` held high, a row takes 5 busy cycles when the second byte is touched and 3 cycles when it is not.
- R11: If `wait_frame` is high when a request is latched, `stall` rises in the cycle after `done`. It then stays high until a cycle in which `frame_tick` is high, and it is low in the cycle after that. With `wait_frame` low, `stall` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| x_in | input | 8 | Horizontal position, reduced modulo 64 |
| y_in | input | 8 | Vertical position, reduced modulo 32 |
| rows_in | input | 4 | Number of sprite rows, 0 to 15 |
| spr_base_in | input | 10 | Address of the first sprite byte |
| fb_base_in | input | 10 | Address of the first frame-buffer byte |
| wait_frame | input | 1 | Ask for a frame stall after this draw |
| frame_tick | input | 1 | Frame tick pulse that releases the stall |
| busy | output | 1 | A draw is in progress |
| done | output | 1 | One-cycle completion pulse |
| collision | output | 1 | A lit pixel was switched off during the last draw |
| stall | output | 1 | Processor should wait for the frame tick |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 10 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after an accepted read |
| mem_ready | input | 1 | Memory accepts the request this cycle |

## Verification
The bench aims at positions where the bytes split unevenly. At X = 61, a design that does not clip would write into the first byte of the next line, which shows up in the memory image and in the access count. At Y = 29 with six rows, a design that does not clip at the bottom would read sprite bytes past the visible rows and write beyond the frame buffer. Drawing the same sprite twice must restore the frame buffer and raise the collision flag. A design that compares against the wrong half of the window, or that does not clear the flag at the next start, would report the wrong flag. Random back-pressure together with a repeated strobe in mid-draw exposes two faults: a design that samples read data in the wrong cycle, and one that accepts a new request while busy.

// File: rtl/blit_pkg.sv
package blit_pkg;

  // Sequencer states; order of the row steps is part of the behaviour.
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_RD_SPR = 3'd1,
    S_RD_B0  = 3'd2,
    S_RD_B1  = 3'd3,
    S_WR_B0  = 3'd4,
    S_WR_B1  = 3'd5,
    S_FIN    = 3'd6
  } blit_state_e;

  // Which holding register takes mem_rdata in the cycle after a read.
  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_SPR  = 2'd1,
    CAP_B0   = 2'd2,
    CAP_B1   = 2'd3
  } cap_sel_e;

  localparam int LANES = 2;

endpackage

// File: rtl/blit_geom.sv
module blit_geom #(
  parameter int AW    = 10,
  parameter int SCR_W = 64,
  parameter int SCR_H = 32,
  parameter int RW    = 4,
  localparam int XW   = $clog2(SCR_W),
  localparam int YW   = $clog2(SCR_H)
) (
  input  logic [XW-1:0] x_pos,
  input  logic [YW-1:0] y_pos,
  input  logic [RW-1:0] row_idx,
  input  logic [AW-1:0] fb_base,
  input  logic [AW-1:0] spr_base,
  input  logic [7:0]    spr_byte,
  output logic [AW-1:0] spr_addr,
  output logic [AW-1:0] row_addr,
  output logic          last_vis,
  output logic          spill_en,
  output logic [7:0]    pat_left,
  output logic [7:0]    pat_right
);
  localparam int BPR = SCR_W / 8;
  localparam int BW  = $clog2(BPR);
  localparam int TW  = ((YW > RW) ? YW : RW) + 1;

  logic [TW-1:0] row_y;
  logic [TW-1:0] row_y_nx;
  logic [15:0]   window;
  logic [BW-1:0] col_byte;

  assign col_byte = x_pos[XW-1:3];
  assign row_y    = TW'(y_pos) + TW'(row_idx);
  assign row_y_nx = row_y + TW'(1);
  // The following row falls below the screen: the current row is the last drawn.
  assign last_vis = (row_y_nx >= TW'(SCR_H));

  assign spr_addr = spr_base + AW'(row_idx);
  assign row_addr = fb_base + AW'({row_y[YW-1:0], {BW{1'b0}}}) + AW'(col_byte);

  assign window   = {spr_byte, 8'h00} >> x_pos[2:0];
  // Second byte only when the sprite straddles a byte and is not in the last column byte.
  assign spill_en = (x_pos[2:0] != 3'd0) && (col_byte != BW'(BPR - 1));
  assign pat_left  = window[15:8];
  assign pat_right = spill_en ? window[7:0] : 8'h00;

endmodule

// File: rtl/blit_merge.sv
module blit_merge (
  input  logic [7:0] old_byte,
  input  logic [7:0] pattern,
  output logic [7:0] new_byte,
  output logic       hit
);
  assign new_byte = old_byte ^ pattern;
  assign hit      = |(old_byte & pattern);
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int AW    = 10,
  parameter int CW    = 8,
  parameter int SCR_W = 64,
  parameter int SCR_H = 32,
  parameter int RW    = 4,
  localparam int XW   = $clog2(SCR_W),
  localparam int YW   = $clog2(SCR_H)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CW-1:0]        x_in,
  input  logic [CW-1:0]        y_in,
  input  logic [RW-1:0]        rows_in,
  input  logic [AW-1:0]        spr_base_in,
  input  logic [AW-1:0]        fb_base_in,
  input  logic                 wait_frame,
  input  logic                 frame_tick,
  output logic                 busy,
  output logic                 done,
  output logic                 collision,
  output logic                 stall,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [7:0]           mem_wdata,
  input  logic [7:0]           mem_rdata,
  input  logic                 mem_ready,
  output logic [XW-1:0]        x_q,
  output logic [YW-1:0]        y_q,
  output logic [RW-1:0]        row_q,
  output logic [AW-1:0]        spr_base_q,
  output logic [AW-1:0]        fb_base_q,
  output logic [7:0]           spr_q,
  output logic [LANES-1:0][7:0] old_v,
  input  logic [AW-1:0]        spr_addr,
  input  logic [AW-1:0]        row_addr,
  input  logic                 last_vis,
  input  logic                 spill_en,
  input  logic [LANES-1:0][7:0] new_v,
  input  logic [LANES-1:0]     hit_v
);
  blit_state_e state_q;
  cap_sel_e    cap_q;
  logic [RW-1:0] rows_q;
  logic [7:0]    b0_q, b1_q;
  logic          wait_q;
  logic          coll_q;
  logic          stall_q;
  logic          row_end;
  logic          unused_hi;

  assign unused_hi = ^{x_in[CW-1:XW], y_in[CW-1:YW]};

  // Forward read data straight into the merge in the cycle it arrives.
  assign old_v[0] = (cap_q == CAP_B0) ? mem_rdata : b0_q;
  assign old_v[1] = (cap_q == CAP_B1) ? mem_rdata : b1_q;

  assign row_end = (({1'b0, row_q} + 1'b1) == {1'b0, rows_q}) || last_vis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cap_q      <= CAP_NONE;
      x_q        <= '0;
      y_q        <= '0;
      rows_q     <= '0;
      row_q      <= '0;
      spr_base_q <= '0;
      fb_base_q  <= '0;
      spr_q      <= '0;
      b0_q       <= '0;
      b1_q       <= '0;
      wait_q     <= 1'b0;
      coll_q     <= 1'b0;
      stall_q    <= 1'b0;
    end else begin
      case (cap_q)
        CAP_SPR: spr_q <= mem_rdata;
        CAP_B0:  b0_q  <= mem_rdata;
        CAP_B1:  b1_q  <= mem_rdata;
        default: ;
      endcase
      cap_q <= CAP_NONE;
      if (frame_tick) stall_q <= 1'b0;

      case (state_q)
        S_IDLE: begin
          if (start) begin
            x_q        <= x_in[XW-1:0];
            y_q        <= y_in[YW-1:0];
            rows_q     <= rows_in;
            row_q      <= '0;
            spr_base_q <= spr_base_in;
            fb_base_q  <= fb_base_in;
            wait_q     <= wait_frame;
            coll_q     <= 1'b0;
            state_q    <= (rows_in == '0) ? S_FIN : S_RD_SPR;
          end
        end
        S_RD_SPR: if (mem_ready) begin
          cap_q   <= CAP_SPR;
          state_q <= S_RD_B0;
        end
        S_RD_B0: if (mem_ready) begin
          cap_q   <= CAP_B0;
          state_q <= spill_en ? S_RD_B1 : S_WR_B0;
        end
        S_RD_B1: if (mem_ready) begin
          cap_q   <= CAP_B1;
          state_q <= S_WR_B0;
        end
        S_WR_B0: if (mem_ready) begin
          coll_q <= coll_q | hit_v[0];
          if (spill_en) begin
            state_q <= S_WR_B1;
          end else if (row_end) begin
            state_q <= S_FIN;
          end else begin
            row_q   <= row_q + 1'b1;
            state_q <= S_RD_SPR;
          end
        end
        S_WR_B1: if (mem_ready) begin
          coll_q <= coll_q | hit_v[1];
          if (row_end) begin
            state_q <= S_FIN;
          end else begin
            row_q   <= row_q + 1'b1;
            state_q <= S_RD_SPR;
          end
        end
        S_FIN: begin
          if (wait_q) stall_q <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = 8'h00;
    case (state_q)
      S_RD_SPR: begin mem_req = 1'b1; mem_addr = spr_addr; end
      S_RD_B0:  begin mem_req = 1'b1; mem_addr = row_addr; end
      S_RD_B1:  begin mem_req = 1'b1; mem_addr = row_addr + AW'(1); end
      S_WR_B0:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = row_addr; mem_wdata = new_v[0]; end
      S_WR_B1:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = row_addr + AW'(1); mem_wdata = new_v[1]; end
      default: ;
    endcase
  end

  assign busy      = (state_q != S_IDLE) && (state_q != S_FIN);
  assign done      = (state_q == S_FIN);
  assign collision = coll_q;
  assign stall     = stall_q;

  // R9: a held-off request keeps its contents until accepted
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: the end of busy is always marked by done
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7: a strobe during a draw leaves the latched request alone
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(x_q) && $stable(y_q) && $stable(rows_q) && $stable(fb_base_q));

  // R11: the stall is only released by a frame tick
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !frame_tick |=> stall);

endmodule

// File: rtl/xor_blitter.sv
module xor_blitter
  import blit_pkg::*;
#(
  parameter int AW    = 10,
  parameter int CW    = 8,
  parameter int SCR_W = 64,
  parameter int SCR_H = 32,
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] x_in,
  input  logic [CW-1:0] y_in,
  input  logic [RW-1:0] rows_in,
  input  logic [AW-1:0] spr_base_in,
  input  logic [AW-1:0] fb_base_in,
  input  logic          wait_frame,
  input  logic          frame_tick,
  output logic          busy,
  output logic          done,
  output logic          collision,
  output logic          stall,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready
);
  localparam int XW       = $clog2(SCR_W);
  localparam int YW       = $clog2(SCR_H);
  localparam int FB_BYTES = SCR_W * SCR_H / 8;

  logic [XW-1:0]  x_q;
  logic [YW-1:0]  y_q;
  logic [RW-1:0]  row_q;
  logic [AW-1:0]  spr_base_q, fb_base_q;
  logic [7:0]     spr_q;
  logic [AW-1:0]  spr_addr, row_addr;
  logic           last_vis, spill_en;
  logic [LANES-1:0][7:0] pat_v, old_v, new_v;
  logic [LANES-1:0]      hit_v;

  blit_geom #(.AW(AW), .SCR_W(SCR_W), .SCR_H(SCR_H), .RW(RW)) u_geom (
    .x_pos     (x_q),
    .y_pos     (y_q),
    .row_idx   (row_q),
    .fb_base   (fb_base_q),
    .spr_base  (spr_base_q),
    .spr_byte  (spr_q),
    .spr_addr  (spr_addr),
    .row_addr  (row_addr),
    .last_vis  (last_vis),
    .spill_en  (spill_en),
    .pat_left  (pat_v[0]),
    .pat_right (pat_v[1])
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    blit_merge u_merge (
      .old_byte (old_v[g]),
      .pattern  (pat_v[g]),
      .new_byte (new_v[g]),
      .hit      (hit_v[g])
    );
  end

  blit_seq #(.AW(AW), .CW(CW), .SCR_W(SCR_W), .SCR_H(SCR_H), .RW(RW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .x_in        (x_in),
    .y_in        (y_in),
    .rows_in     (rows_in),
    .spr_base_in (spr_base_in),
    .fb_base_in  (fb_base_in),
    .wait_frame  (wait_frame),
    .frame_tick  (frame_tick),
    .busy        (busy),
    .done        (done),
    .collision   (collision),
    .stall       (stall),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ready   (mem_ready),
    .x_q         (x_q),
    .y_q         (y_q),
    .row_q       (row_q),
    .spr_base_q  (spr_base_q),
    .fb_base_q   (fb_base_q),
    .spr_q       (spr_q),
    .old_v       (old_v),
    .spr_addr    (spr_addr),
    .row_addr    (row_addr),
    .last_vis    (last_vis),
    .spill_en    (spill_en),
    .new_v       (new_v),
    .hit_v       (hit_v)
  );

  // R4, R5: every write lands inside the frame buffer
  p_fb_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> ((mem_addr - fb_base_q) < AW'(FB_BYTES)));

  // R8: no memory traffic outside a draw
  p_req_in_draw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy && !done);

endmodule

// File: tb/xor_blitter_tb.sv
module xor_blitter_tb;
  localparam int AW    = 10;
  localparam int MEM_N = 1 << AW;
  localparam int SRC   = 'h040;
  localparam int FB    = 'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] x_in = '0, y_in = '0;
  logic [3:0] rows_in = '0;
  logic [AW-1:0] spr_base_in = AW'(SRC), fb_base_in = AW'(FB);
  logic wait_frame = 1'b0, frame_tick = 1'b0;
  logic busy, done, collision, stall, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'hA5;
  logic mem_ready = 1'b1;

  // bench memory and host port
  logic [7:0] mem [0:MEM_N-1];
  logic [7:0] exp_m [0:MEM_N-1];
  logic host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_data = '0;
  logic wipe = 1'b0, log_clr = 1'b0, bp_en = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  int log_n = 0, oob_n = 0;
  logic log_we [0:63];
  logic [AW-1:0] log_addr [0:63];

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  xor_blitter u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .rows_in(rows_in), .spr_base_in(spr_base_in), .fb_base_in(fb_base_in),
    .wait_frame(wait_frame), .frame_tick(frame_tick), .busy(busy), .done(done),
    .collision(collision), .stall(stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  always @(posedge clk) begin
    mem_rdata <= 8'hA5;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= !bp_en || (lfsr[1] & lfsr[4]) || lfsr[6];
    if (wipe) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= 8'h00;
    end else if (host_we) begin
      mem[host_addr] <= host_data;
    end
    if (log_clr) begin
      log_n <= 0;
      oob_n <= 0;
    end else if (mem_req && mem_ready) begin
      if (log_n < 64) begin
        log_we[log_n]   <= mem_we;
        log_addr[log_n] <= mem_addr;
      end
      log_n <= log_n + 1;
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        if (int'(mem_addr) < FB || int'(mem_addr) >= FB + 256) oob_n <= oob_n + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); wipe = 1'b1;
    @(negedge clk); wipe = 1'b0;
    for (int i = 0; i < MEM_N; i++) exp_m[i] = 8'h00;
  endtask

  task automatic poke(input int a, input logic [7:0] v);
    exp_m[a] = v;
    @(negedge clk);
    host_we = 1'b1; host_addr = AW'(a); host_data = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_sprite(input logic [127:0] pat, input int n);
    for (int r = 0; r < n; r++) poke(SRC + r, pat[127 - 8*r -: 8]);
  endtask

  // reference draw on the expected image
  task automatic ref_draw(input int x, input int y, input int n,
                          output bit c, output int cyc);
    int xr, yr, a, sh;
    logic [15:0] w;
    logic [7:0] lft, rgt;
    bit sp;
    xr = x % 64; yr = y % 32; c = 0; cyc = 0;
    for (int r = 0; r < n; r++) begin
      if (yr + r >= 32) break;
      sh = xr % 8;
      w = {exp_m[SRC + r], 8'h00} >> sh;
      sp = (sh != 0) && (xr / 8 != 7);
      a = FB + (yr + r) * 8 + xr / 8;
      lft = w[15:8];
      rgt = sp ? w[7:0] : 8'h00;
      if ((exp_m[a] & lft) != 0) c = 1;
      exp_m[a] = exp_m[a] ^ lft;
      if (sp) begin
        if ((exp_m[a+1] & rgt) != 0) c = 1;
        exp_m[a+1] = exp_m[a+1] ^ rgt;
      end
      cyc += sp ? 5 : 3;
    end
  endtask

  task automatic run_draw(input int x, input int y, input int n, input bit wt,
                          output bit c, output int bcyc);
    int guard;
    @(negedge clk);
    x_in = 8'(x); y_in = 8'(y); rows_in = 4'(n); wait_frame = wt;
    start = 1'b1; log_clr = 1'b1;
    @(negedge clk);
    start = 1'b0; log_clr = 1'b0;
    bcyc = 0; guard = 0;
    while (!done && guard < 3000) begin
      if (busy) bcyc++;
      guard++;
      @(negedge clk);
    end
    if (guard >= 3000) chk(0, "R7 done timeout", guard, 0);
    c = collision;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < MEM_N; i++)
      if (mem[i] !== exp_m[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, req, first, -1);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_req && !collision && !stall, "R7 reset state",
        int'({busy, done, mem_req, collision, stall}), 0);
  endtask

  task automatic t_aligned();
    bit c, ec; int bc, ecyc;
    clear_all();
    set_sprite({8'hF0, 8'h0F, 8'h81, 104'h0}, 3);
    ref_draw(8, 0, 3, ec, ecyc);
    run_draw(8, 0, 3, 0, c, bc);
    cmp_mem("R2 aligned image");
    chk(bc == ecyc, "R10 aligned busy cycles", bc, ecyc);
    chk(c == ec, "R6 aligned collision", c, ec);
    chk(log_n == 9 && !log_we[0] && log_addr[0] == AW'(SRC) && !log_we[1] &&
        log_addr[1] == AW'(FB + 1) && log_we[2] && log_addr[2] == AW'(FB + 1),
        "R10 aligned access order", log_n, 9);
  endtask

  task automatic t_unaligned();
    bit c, ec; int bc, ecyc, a;
    clear_all();
    set_sprite({8'hB5, 8'hFF, 112'h0}, 2);
    poke(FB + 5*8 + 1, 8'h00);
    ref_draw(13, 5, 2, ec, ecyc);
    run_draw(13, 5, 2, 0, c, bc);
    cmp_mem("R3 unaligned image");
    chk(bc == ecyc && bc == 10, "R10 unaligned busy cycles", bc, 10);
    a = FB + 5*8 + 1;
    chk(log_n == 10 && !log_we[0] && log_addr[0] == AW'(SRC) &&
        !log_we[1] && log_addr[1] == AW'(a) && !log_we[2] && log_addr[2] == AW'(a+1) &&
        log_we[3] && log_addr[3] == AW'(a) && log_we[4] && log_addr[4] == AW'(a+1),
        "R10 unaligned access order", log_n, 10);
  endtask

  task automatic t_right_clip();
    bit c, ec; int bc, ecyc;
    clear_all();
    set_sprite({8'hFF, 8'hFF, 8'hFF, 8'hFF, 96'h0}, 4);
    ref_draw(61, 2, 4, ec, ecyc);
    run_draw(61, 2, 4, 0, c, bc);
    cmp_mem("R4 right edge image");
    chk(log_n == 12 && bc == 12, "R4 no second byte access", log_n, 12);
    chk(mem[FB + 3*8] == 8'h00, "R4 no wrap into next line", mem[FB + 3*8], 0);
  endtask

  task automatic t_bottom_clip();
    bit c, ec; int bc, ecyc;
    clear_all();
    set_sprite({8'hC3, 8'h3C, 8'h99, 8'h11, 8'h22, 8'h44, 80'h0}, 6);
    ref_draw(0, 29, 6, ec, ecyc);
    run_draw(0, 29, 6, 0, c, bc);
    cmp_mem("R5 bottom clip image");
    chk(bc == 9 && log_n == 9, "R5 stops after three rows", bc, 9);
    chk(oob_n == 0, "R5 no write past buffer", oob_n, 0);
  endtask

  task automatic t_collision();
    bit c, ec; int bc, ecyc;
    clear_all();
    set_sprite({8'h18, 8'h3C, 112'h0}, 2);
    ref_draw(20, 10, 2, ec, ecyc);
    run_draw(20, 10, 2, 0, c, bc);
    chk(c == 0 && ec == 0, "R6 first draw no collision", c, 0);
    ref_draw(20, 10, 2, ec, ecyc);
    run_draw(20, 10, 2, 0, c, bc);
    chk(c == 1 && ec == 1, "R6 redraw collides", c, 1);
    cmp_mem("R6 redraw erases sprite");
    // flag cleared by next start on empty area
    run_draw(40, 20, 1, 0, c, bc);
    ref_draw(40, 20, 1, ec, ecyc);
    chk(c == 0, "R6 flag cleared at start", c, 0);
  endtask

  task automatic t_zero_rows();
    bit c, ec; int bc, ecyc;
    clear_all();
    set_sprite({8'hFF, 120'h0}, 1);
    poke(FB, 8'hFF);
    ref_draw(0, 0, 1, ec, ecyc);
    run_draw(0, 0, 1, 0, c, bc);
    chk(c == 1, "R6 collision before empty draw", c, 1);
    run_draw(0, 0, 0, 0, c, bc);
    chk(bc == 0 && log_n == 0, "R8 zero rows no access", log_n, 0);
    chk(c == 0, "R8 zero rows collision low", c, 0);
    cmp_mem("R8 zero rows image unchanged");
  endtask

  task automatic t_modulo();
    bit c, ec; int bc, ecyc;
    clear_all();
    set_sprite({8'hA5, 8'h5A, 8'hE7, 104'h0}, 3);
    ref_draw(6, 8, 3, ec, ecyc);
    run_draw(70, 40, 3, 0, c, bc);
    cmp_mem("R1 wrapped coordinates");
  endtask

  task automatic t_backpressure();
    bit c, ec; int bc, ecyc;
    clear_all();
    set_sprite({8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h77, 88'h0}, 5);
    poke(FB + 12*8 + 3, 8'h40);
    poke(FB + 14*8 + 4, 8'hFF);
    bp_en = 1'b1;
    ref_draw(27, 10, 5, ec, ecyc);
    run_draw(27, 10, 5, 0, c, bc);
    bp_en = 1'b0;
    cmp_mem("R9 image under back-pressure");
    chk(c == ec, "R9 collision under back-pressure", c, ec);
    chk(bc >= ecyc, "R9 stretched busy", bc, ecyc);
  endtask

  task automatic t_start_ignored();
    bit ec; int bc, ecyc, guard;
    clear_all();
    set_sprite({8'h81, 8'h42, 8'h24, 8'h18, 96'h0}, 4);
    ref_draw(3, 3, 4, ec, ecyc);
    @(negedge clk);
    x_in = 8'd3; y_in = 8'd3; rows_in = 4'd4; wait_frame = 1'b0;
    start = 1'b1; log_clr = 1'b1;
    @(negedge clk); start = 1'b0; log_clr = 1'b0;
    bc = (busy) ? 1 : 0;
    @(negedge clk);
    if (busy) bc++;
    x_in = 8'd40; y_in = 8'd20; rows_in = 4'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (!done && guard < 3000) begin
      if (busy) bc++;
      guard++;
      @(negedge clk);
    end
    cmp_mem("R7 second start ignored");
    chk(bc == ecyc, "R7 busy length unchanged", bc, ecyc);
    @(negedge clk);
    chk(!busy && !done, "R7 idle after done", busy, 0);
  endtask

  task automatic t_stall();
    bit c, ec; int bc, ecyc;
    clear_all();
    set_sprite({8'h3C, 120'h0}, 1);
    ref_draw(0, 0, 1, ec, ecyc);
    run_draw(0, 0, 1, 1, c, bc);
    @(negedge clk);
    chk(stall == 1, "R11 stall raised after done", stall, 1);
    repeat (4) @(negedge clk);
    chk(stall == 1, "R11 stall held", stall, 1);
    frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
    chk(stall == 0, "R11 stall released by tick", stall, 0);
    run_draw(8, 0, 1, 0, c, bc);
    ref_draw(8, 0, 1, ec, ecyc);
    @(negedge clk);
    chk(stall == 0, "R11 no stall without request", stall, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_unaligned();
    t_right_clip();
    t_bottom_clip();
    t_collision();
    t_zero_rows();
    t_modulo();
    t_backpressure();
    t_start_ignored();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule